// File: doc/BRIEF.md
# Auto-Stepping Video Memory Access Port

This block lets an 8-bit host processor reach a 20-bit video memory space through eight byte-wide registers instead of a direct mapping. Two independent data ports each keep their own 20-bit pointer and step code. A selector bit in the control register decides which pointer the three shared address registers edit and show. Each access to a data port moves that port's pointer forward by a power-of-two step. This allows a run of bytes to be streamed without reloading the address.

On the memory side, the block drives a single synchronous request interface. Read data returns one cycle after the request. Writes through a data port go to memory in the same cycle as the host strobe. Reads are served from a byte per port that was fetched ahead of time. The block refetches that byte after every pointer change. The block also classifies the address on the memory bus into RAM, one of the configuration-register windows, or unmapped space.

Top module: `vmem_port`

## Requirements
- R1: After reset, port 0 is selected, both pointers and both step codes are zero, and the control and interrupt-enable registers read as zero.
- R2: Host register offsets are: 0 pointer bits 7:0, 1 pointer bits 15:8, 2 pointer high, 3 data port 0, 4 data port 1, 5 control, 6 interrupt enable, 7 interrupt status. Offsets 0 to 2 read and write the pointer of the selected port.
- R3: The pointer-high register holds the step code in bits 7:4 and pointer bits 19:16 in bits 3:0, and it reads back in the same layout.
- R4: Step code 0 gives a step of 0. A code n from 1 to 15 gives a step of 2^(n-1), so code 15 gives 16384.
- R5: A host write to a data port drives mem_req=1, mem_we=1, mem_addr equal to that port's pointer and mem_wdata equal to the host byte in the same cycle. The pointer then advances by its step.
- R6: A host read of a data port returns the byte at its current pointer. That byte was fetched from memory after the last pointer change. The pointer then advances and a new fetch is issued. A fetch is issued the cycle after the change, and its data is held two cycles after the change.
- R7: Control bit 0 selects the port. Writing control with bit 7 set clears both pointers and both step codes and selects port 0. Control bit 7 always reads 0.
- R8: Pointer arithmetic wraps modulo 2^20.
- R9: mem_region encodes mem_addr as follows: 1 for 0x00000 to 0x1FFFF (RAM), and 2+k for 0xFk000 to 0xFkFFF with k from 0 to 8. These windows are composer, palette, layer 0, layer 1, sprite registers, sprite attributes, audio, SPI and UART. Any other address gives 0.
- R10: The interrupt-enable register stores and returns any byte. The interrupt-status register reads 0 and ignores writes.
- R11: Editing or stepping one port leaves the other port's pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 20 | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after request |
| mem_region | output | 4 | Region code of mem_addr |

## Verification
The bench builds the block with its defaults: two data ports and a 20-bit pointer. With these values, the largest step can carry a pointer near 0xFFFFF past the top of the space, so wraparound is exercised directly. Both ports are stepped from the same shared address registers, so any crosstalk between pointers is visible. The memory model returns an address-derived byte. Every prefetched value can therefore be predicted from the pointer alone.

// File: rtl/vap_pkg.sv
package vap_pkg;
  localparam int unsigned VAP_ADDR_W = 20;
  localparam int unsigned VAP_PORTS  = 2;

  typedef enum logic [2:0] {
    REG_PTR_L  = 3'd0,
    REG_PTR_M  = 3'd1,
    REG_PTR_H  = 3'd2,
    REG_DATA0  = 3'd3,
    REG_DATA1  = 3'd4,
    REG_CTRL   = 3'd5,
    REG_IRQ_EN = 3'd6,
    REG_IRQ_ST = 3'd7
  } vap_reg_e;

  // Power-of-two step selected by a 4-bit code; code 0 means no movement.
  function automatic logic [31:0] vap_step(input logic [3:0] code);
    if (code == 4'd0) return 32'd0;
    return 32'd1 << (code - 4'd1);
  endfunction

  // Region code: 1 = RAM, 2+k = window 0xFk000..0xFkFFF (k=0..8), 0 = unmapped.
  function automatic logic [3:0] vap_region(input logic [19:0] a);
    if (a < 20'h20000) return 4'd1;
    if (a[19:16] == 4'hF && a[15:12] <= 4'd8) return 4'd2 + a[15:12];
    return 4'd0;
  endfunction
endpackage

// File: rtl/vap_pointer.sv
module vap_pointer #(
  parameter int unsigned ADDR_W = vap_pkg::VAP_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_lo,
  input  logic              wr_mid,
  input  logic              wr_hi,
  input  logic [7:0]        wdata,
  input  logic              bump,
  output logic [ADDR_W-1:0] ptr,
  output logic [3:0]        code
);
  localparam int unsigned HI_W = ADDR_W - 16;

  logic [ADDR_W-1:0] step_w;
  assign step_w = ADDR_W'(vap_pkg::vap_step(code));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ptr  <= '0;
      code <= '0;
    end else if (bump) begin
      ptr <= ptr + step_w;
    end else begin
      if (wr_lo)  ptr[7:0]  <= wdata;
      if (wr_mid) ptr[15:8] <= wdata;
      if (wr_hi) begin
        ptr[ADDR_W-1:16] <= wdata[HI_W-1:0];
        code             <= wdata[7:4];
      end
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr == '0 && code == 4'd0)); // R7
  AST_BUMP_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !clr) |=> $stable(code)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bump || clr || wr_lo || wr_mid || wr_hi) |=> $stable(ptr)); // R11
endmodule

// File: rtl/vap_mem_seq.sv
module vap_mem_seq #(
  parameter int unsigned ADDR_W = vap_pkg::VAP_ADDR_W,
  parameter int unsigned NP     = vap_pkg::VAP_PORTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_go,
  input  logic [PW-1:0]             wr_port,
  input  logic [7:0]                wr_data,
  input  logic [NP-1:0]             kick,
  input  logic [NP-1:0][ADDR_W-1:0] ptrs,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [7:0]                mem_wdata,
  input  logic [7:0]                mem_rdata,
  output logic [NP-1:0][7:0]        held
);
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1;

  logic [NP-1:0] pend_q;
  logic [NP-1:0] issue_vec;
  logic          issue_go;
  logic [PW-1:0] issue_idx;
  logic          fly_q;
  logic [PW-1:0] fly_idx;

  // Lowest-numbered pending port wins; a host write takes the bus first.
  always_comb begin
    issue_go  = 1'b0;
    issue_idx = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        issue_go  = !wr_go;
        issue_idx = PW'(i);
      end
    end
    issue_vec = '0;
    if (issue_go) issue_vec[issue_idx] = 1'b1;
  end

  assign mem_req   = wr_go | issue_go;
  assign mem_we    = wr_go;
  assign mem_addr  = wr_go ? ptrs[wr_port] : ptrs[issue_idx];
  assign mem_wdata = wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '1;
      fly_q   <= 1'b0;
      fly_idx <= '0;
      held    <= '0;
    end else begin
      pend_q  <= (pend_q & ~issue_vec) | kick;
      fly_q   <= issue_go;
      fly_idx <= issue_idx;
      if (fly_q) held[fly_idx] <= mem_rdata;
    end
  end

  AST_WRITE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> (mem_req && mem_we)); // R5
  AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_vec)); // R6
  AST_CAPTURE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> fly_q); // R6
endmodule

// File: rtl/vmem_port.sv
module vmem_port #(
  parameter int unsigned ADDR_W = vap_pkg::VAP_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [2:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [3:0]        mem_region
);
  import vap_pkg::*;
  localparam int unsigned NP = VAP_PORTS;
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1;

  logic [NP-1:0][ADDR_W-1:0] ptrs;
  logic [NP-1:0][3:0]        codes;
  logic [NP-1:0][7:0]        held;
  logic [NP-1:0]             kick;
  logic [NP-1:0]             bump;
  logic [PW-1:0]             sel_q;
  logic [7:0]                irq_en_q;
  logic                      clr_all;
  logic                      wr_go;
  logic [PW-1:0]             wr_port;

  assign clr_all = host_wr && host_addr == REG_CTRL && host_wdata[7];

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic edit_lo, edit_mid, edit_hi;
    assign edit_lo  = host_wr && host_addr == REG_PTR_L && sel_q == PW'(p);
    assign edit_mid = host_wr && host_addr == REG_PTR_M && sel_q == PW'(p);
    assign edit_hi  = host_wr && host_addr == REG_PTR_H && sel_q == PW'(p);
    assign bump[p]  = (host_wr || host_rd) && host_addr == 3'(REG_DATA0 + p);
    assign kick[p]  = clr_all | edit_lo | edit_mid | edit_hi | bump[p];

    vap_pointer #(.ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .clr(clr_all),
      .wr_lo(edit_lo), .wr_mid(edit_mid), .wr_hi(edit_hi),
      .wdata(host_wdata), .bump(bump[p]),
      .ptr(ptrs[p]), .code(codes[p])
    );
  end

  assign wr_go   = host_wr && (host_addr == REG_DATA0 || host_addr == REG_DATA1);
  assign wr_port = PW'(host_addr == REG_DATA1);

  vap_mem_seq #(.ADDR_W(ADDR_W), .NP(NP)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_go(wr_go), .wr_port(wr_port), .wr_data(host_wdata),
    .kick(kick), .ptrs(ptrs),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .held(held)
  );

  assign mem_region = vap_region(mem_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      irq_en_q <= '0;
    end else begin
      if (clr_all) sel_q <= '0;
      else if (host_wr && host_addr == REG_CTRL) sel_q <= PW'(host_wdata[0]);
      if (host_wr && host_addr == REG_IRQ_EN) irq_en_q <= host_wdata;
    end
  end

  always_comb begin
    unique case (host_addr)
      REG_PTR_L:  host_rdata = ptrs[sel_q][7:0];
      REG_PTR_M:  host_rdata = ptrs[sel_q][15:8];
      REG_PTR_H:  host_rdata = {codes[sel_q], ptrs[sel_q][ADDR_W-1:16]};
      REG_DATA0:  host_rdata = held[0];
      REG_DATA1:  host_rdata = held[NP-1];
      REG_CTRL:   host_rdata = {7'd0, sel_q[0]};
      REG_IRQ_EN: host_rdata = irq_en_q;
      default:    host_rdata = 8'd0;
    endcase
  end

  AST_CTRL_TOP_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd5) |-> host_rdata[7] == 1'b0); // R7
  AST_STATUS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd7) |-> host_rdata == 8'd0); // R10
  AST_RAM_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_addr[19:17] == 3'd0) |-> mem_region == 4'd1); // R9
endmodule

// File: tb/vmem_port_tb.sv
module vmem_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [3:0]  mem_region;

  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vmem_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_region(mem_region)
  );

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h5, a[19:16]};
  endfunction

  always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= pat(mem_addr);

  typedef struct packed {
    logic        sel;
    logic [3:0]  code;
    logic [19:0] base;
    logic [19:0] nxt;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 4'd0,  20'h00100, 20'h00100},
    '{1'b0, 4'd1,  20'h00100, 20'h00101},
    '{1'b1, 4'd2,  20'h00100, 20'h00102},
    '{1'b1, 4'd6,  20'h12345, 20'h12365},
    '{1'b0, 4'd15, 20'h1FFFF, 20'h23FFF},
    '{1'b1, 4'd15, 20'hFC000, 20'h00000},
    '{1'b0, 4'd11, 20'hFFC00, 20'h00000}
  };

  logic        cap_req, cap_we;
  logic [19:0] cap_addr;
  logic [7:0]  cap_wdata;
  logic [3:0]  cap_region;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    #1;
    cap_req = mem_req; cap_we = mem_we; cap_addr = mem_addr;
    cap_wdata = mem_wdata; cap_region = mem_region;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ptr(input logic [19:0] a, input logic [3:0] code);
    wr(3'd0, a[7:0]);
    wr(3'd1, a[15:8]);
    wr(3'd2, {code, a[19:16]});
    idle(4);
  endtask

  task automatic read_ptr(output logic [19:0] a, output logic [3:0] code);
    logic [7:0] b0, b1, b2;
    rd(3'd0, b0); rd(3'd1, b1); rd(3'd2, b2);
    a = {b2[3:0], b1, b0};
    code = b2[7:4];
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [19:0] p;
    logic [3:0]  c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    read_ptr(p, c);
    check("R1 ptr", p, 0);
    check("R1 code", c, 0);
    rd(3'd5, d); check("R1 ctrl", d, 0);
    rd(3'd6, d); check("R1 irq_en", d, 0);
    rd(3'd3, d); check("R1 R6 data0 at 0", d, pat(20'h0));

    // R2 R3 R4 R5 R8: vector walk
    for (int i = 0; i < 7; i++) begin
      wr(3'd5, {7'd0, VECS[i].sel});
      set_ptr(VECS[i].base, VECS[i].code);
      wr(VECS[i].sel ? 3'd4 : 3'd3, 8'hA0 + 8'(i));
      check("R5 req/we", {cap_req, cap_we}, 2'b11);
      check("R5 addr", cap_addr, VECS[i].base);
      check("R5 wdata", cap_wdata, 8'hA0 + 8'(i));
      read_ptr(p, c);
      check("R4 R8 next ptr", p, VECS[i].nxt);
      check("R3 code readback", c, VECS[i].code);
    end

    // R6: prefetched read and advance
    wr(3'd5, 8'h80);
    set_ptr(20'h00500, 4'd1);
    rd(3'd3, d); check("R6 first read", d, pat(20'h00500));
    idle(4);
    rd(3'd3, d); check("R6 after advance", d, pat(20'h00501));
    read_ptr(p, c); check("R6 ptr moved", p, 20'h00502);

    // R11: other port untouched
    wr(3'd5, 8'h01);
    set_ptr(20'h00ABC, 4'd3);
    rd(3'd4, d); check("R11 R6 port1 read", d, pat(20'h00ABC));
    wr(3'd5, 8'h00);
    read_ptr(p, c); check("R11 port0 ptr", p, 20'h00502);
    wr(3'd5, 8'h01);
    read_ptr(p, c); check("R11 port1 ptr", p, 20'h00AC0);

    // R7: global clear
    wr(3'd5, 8'h81);
    rd(3'd5, d); check("R7 ctrl after clear", d, 0);
    read_ptr(p, c); check("R7 port0 cleared", {c, p}, 0);
    wr(3'd5, 8'h01);
    read_ptr(p, c); check("R7 port1 cleared", {c, p}, 0);
    wr(3'd5, 8'h00);

    // R9: region codes
    set_ptr(20'hF1000, 4'd0); wr(3'd3, 8'h11); check("R9 palette", cap_region, 3);
    set_ptr(20'h1FFFF, 4'd0); wr(3'd3, 8'h11); check("R9 ram top", cap_region, 1);
    set_ptr(20'h20000, 4'd0); wr(3'd3, 8'h11); check("R9 unmapped", cap_region, 0);
    set_ptr(20'hF8003, 4'd0); wr(3'd3, 8'h11); check("R9 uart", cap_region, 10);
    set_ptr(20'hF9000, 4'd0); wr(3'd3, 8'h11); check("R9 above windows", cap_region, 0);

    // R10: interrupt registers
    wr(3'd6, 8'h3C); rd(3'd6, d); check("R10 irq_en", d, 8'h3C);
    wr(3'd7, 8'hFF); rd(3'd7, d); check("R10 irq_st", d, 8'h00);
    read_ptr(p, c); check("R10 R2 status write harmless", p, 20'hF9000);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule